// File: doc/BRIEF.md
# Physical Memory Protection Permission Checker

This block decides, in a single combinational pass, whether one memory access may proceed. It sees the physical byte address of the access, the kind of access (load, store or instruction fetch), and whether the hart is running in machine mode or at a lower privilege. Alongside these it sees the configuration byte and the address register of every protection entry. It returns an allow bit, a hit flag, and the number of the entry that decided the result.

Each entry matches addresses in one of four ways: disabled, top of range, a single aligned word, or an aligned power-of-two region. The lowest-numbered entry that matches decides the outcome. Its read, write and execute bits govern lower-privilege accesses. They govern machine-mode accesses only when the entry's lock bit is set. The block sits next to the load/store unit and the fetch unit, and a trap generator consumes its allow bit.

Top module: `pmp_access_checker`

## Requirements
- R1: An entry whose mode field (configuration bits 4:3) is 0 matches no address, whatever its address register and permission bits hold.
- R2: Mode 1 matches when lower <= acc_addr>>2 < upper. Upper is the entry's own address register. Lower is the address register of the entry numbered one below, or zero for entry 0. When lower >= upper, the entry matches nothing.
- R3: Mode 2 matches exactly the four bytes whose acc_addr>>2 equals the entry's address register.
- R4: Mode 3 with k trailing ones in the address register matches a naturally aligned region of 2^(k+3) bytes. Only the word-address bits above bit k are compared. An address register of all ones matches every address.
- R5: When several entries match, the lowest-numbered one decides. Its number appears on hit_idx, with hit high.
- R6: In configuration bits, bit 0 grants read, bit 1 grants write and bit 2 grants execute. acc_kind 0 is a load, 1 is a store, and 2 or 3 is a fetch. A non-machine access that hits is allowed exactly when the decisive entry's bit for its kind is set.
- R7: A machine-mode access that hits an entry whose lock bit (configuration bit 7) is clear is allowed, whatever the permission bits hold.
- R8: A machine-mode access that hits a locked entry is allowed exactly when that entry's permission bit for the access kind is set.
- R9: When no entry matches, hit is low, machine-mode accesses are allowed, and non-machine accesses are denied.
- R10: Configuration bits 6:5 have no effect on matching or on the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr | input | PA_W | Physical byte address of the access |
| acc_kind | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| acc_mach | input | 1 | High when the effective privilege is machine mode |
| ent_cfg | input | ENTRIES*8 | Configuration bytes; entry i in bits 8i+7..8i |
| ent_addr | input | ENTRIES*(PA_W-2) | Address registers (byte address >> 2); entry i in slice i |
| allow | output | 1 | Access permitted |
| hit | output | 1 | Some entry matched |
| hit_idx | output | IDX_W | Number of the deciding entry (0 when hit is low) |

## Verification
Because the block holds no state, any fault in a match term or in the priority scan shows up at the ports as soon as the inputs settle. A wrong hit_idx exposes a broken priority scan. A wrong hit exposes a faulty range comparison. A wrong allow with a correct hit_idx points at permission selection or at the lock and privilege handling. Directed cases probe range edges, inverted bounds, overlap and locking, and randomized configurations over a small address space make overlapping entries of mixed modes common.

// File: rtl/pmp_access_checker.sv
module pmp_access_checker #(
  parameter int ENTRIES = 8,
  parameter int PA_W    = 34,
  localparam int AW     = PA_W - 2,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [PA_W-1:0]       acc_addr,
  input  logic [1:0]            acc_kind,
  input  logic                  acc_mach,
  input  logic [ENTRIES*8-1:0]  ent_cfg,
  input  logic [ENTRIES*AW-1:0] ent_addr,
  output logic                  allow,
  output logic                  hit,
  output logic [IDX_W-1:0]      hit_idx
);

  logic [AW-1:0]          word;
  logic [ENTRIES-1:0]     match;
  logic [2*ENTRIES-1:0]   unused_rsvd;
  logic                   sel_lock;
  logic [2:0]             sel_perm;
  logic                   perm_ok;

  assign word = acc_addr[PA_W-1:2];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [AW-1:0] top, low, span;
    logic [1:0]    mode;

    assign top  = ent_addr[i*AW +: AW];
    assign mode = ent_cfg[i*8+3 +: 2];
    assign span = top ^ (top + 1'b1);
    assign unused_rsvd[2*i +: 2] = ent_cfg[i*8+5 +: 2];

    if (i == 0) begin : g_base
      assign low = '0;
    end else begin : g_prev
      assign low = ent_addr[(i-1)*AW +: AW];
    end

    always_comb begin
      unique case (mode)
        2'd1:    match[i] = (word >= low) && (word < top);
        2'd2:    match[i] = (word == top);
        2'd3:    match[i] = ((word ^ top) & ~span) == '0;
        default: match[i] = 1'b0;
      endcase
    end

    always_comb begin
      if (mode == 2'd0) assert_off_silent_R1: assert (!match[i]);
    end
  end

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    sel_lock = 1'b0;
    sel_perm = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit      = 1'b1;
        hit_idx  = IDX_W'(i);
        sel_lock = ent_cfg[i*8+7];
        sel_perm = ent_cfg[i*8 +: 3];
      end
    end
  end

  assign perm_ok = acc_kind[1] ? sel_perm[2] : (acc_kind[0] ? sel_perm[1] : sel_perm[0]);
  assign allow   = hit ? ((acc_mach && !sel_lock) || perm_ok) : acc_mach;

  always_comb begin
    if (hit) begin
      assert_first_hit_R5: assert (match[hit_idx] &&
        ((match & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0));
      if (acc_mach && !ent_cfg[int'(hit_idx)*8+7])
        assert_mach_unlocked_R7: assert (allow);
      if (ent_cfg[int'(hit_idx)*8+7] && ent_cfg[int'(hit_idx)*8 +: 3] == 3'b000)
        assert_locked_empty_R8: assert (!allow);
      if (!acc_mach && ent_cfg[int'(hit_idx)*8 +: 3] == 3'b000)
        assert_lowpriv_empty_R6: assert (!allow);
    end else begin
      assert_no_hit_default_R9: assert (allow == acc_mach && match == '0);
    end
  end

endmodule

// File: tb/pmp_access_checker_test.sv
module pmp_access_checker_test;
  localparam int N  = 8;
  localparam int PW = 34;
  localparam int AW = PW - 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [PW-1:0]   acc_addr = '0;
  logic [1:0]      acc_kind = '0;
  logic            acc_mach = 1'b0;
  logic [N*8-1:0]  ent_cfg  = '0;
  logic [N*AW-1:0] ent_addr = '0;
  logic            allow, hit;
  logic [2:0]      hit_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pmp_access_checker #(.ENTRIES(N), .PA_W(PW)) uut (
    .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_mach(acc_mach),
    .ent_cfg(ent_cfg), .ent_addr(ent_addr),
    .allow(allow), .hit(hit), .hit_idx(hit_idx));

  function automatic bit ent_match(int i, logic [AW-1:0] w);
    logic [AW-1:0] t, lo;
    int k;
    t  = ent_addr[i*AW +: AW];
    lo = (i == 0) ? '0 : ent_addr[(i-1)*AW +: AW];
    case (ent_cfg[i*8+3 +: 2])
      2'd1: return (w >= lo) && (w < t);
      2'd2: return w == t;
      2'd3: begin
        k = 0;
        while (k < AW && t[k]) k++;
        if (k >= AW - 1) return 1'b1;
        return (w >> (k + 1)) == (t >> (k + 1));
      end
      default: return 1'b0;
    endcase
  endfunction

  task automatic model(output bit ea, output bit eh, output int ei);
    bit p;
    logic [7:0] c;
    eh = 0; ei = 0; ea = acc_mach;
    for (int i = 0; i < N; i++) begin
      if (!eh && ent_match(i, acc_addr[PW-1:2])) begin
        eh = 1; ei = i;
      end
    end
    if (eh) begin
      c = ent_cfg[ei*8 +: 8];
      p = (acc_kind == 2'd0) ? c[0] : (acc_kind == 2'd1) ? c[1] : c[2];
      ea = p || (acc_mach && !c[7]);
    end
  endtask

  task automatic put(int i, logic [7:0] c, logic [AW-1:0] a);
    ent_cfg[i*8 +: 8] = c;
    ent_addr[i*AW +: AW] = a;
  endtask

  task automatic clear_all();
    ent_cfg = '0;
    ent_addr = '0;
  endtask

  task automatic check(string tag, logic [PW-1:0] a, logic [1:0] k, logic m,
                       bit ea, bit eh, int ei);
    @(posedge clk);
    acc_addr = a; acc_kind = k; acc_mach = m;
    @(negedge clk);
    checks++;
    if (allow !== ea || hit !== eh || (eh && int'(hit_idx) != ei)) begin
      errors++;
      $display("FAIL %s addr=%h kind=%0d mach=%0b: got allow=%0b hit=%0b idx=%0d, expected allow=%0b hit=%0b idx=%0d",
               tag, a, k, m, allow, hit, hit_idx, ea, eh, ei);
    end
  endtask

  task automatic check_model(string tag, logic [PW-1:0] a, logic [1:0] k, logic m);
    bit ea, eh;
    int ei;
    acc_addr = a; acc_kind = k; acc_mach = m;
    model(ea, eh, ei);
    check(tag, a, k, m, ea, eh, ei);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(posedge clk);

    // R9: all entries off after start
    check("R9 empty mach", 34'h0, 2'd1, 1'b1, 1, 0, 0);
    check("R9 empty user", 34'h0, 2'd0, 1'b0, 0, 0, 0);

    // R1: off entry with full permissions covers nothing
    put(0, 8'h07, 32'h100);
    check("R1 off entry", 34'h10, 2'd0, 1'b0, 0, 0, 0);
    put(0, 8'h87, 32'hFFFF_FFFF);
    check("R1 off locked", 34'h3FC, 2'd2, 1'b0, 0, 0, 0);

    // R2: top of range
    clear_all();
    put(0, 8'h0F, 32'h100);
    check("R2 tor0 last word", 34'h3FC, 2'd0, 1'b0, 1, 1, 0);
    check("R2 tor0 zero", 34'h0, 2'd0, 1'b0, 1, 1, 0);
    check("R2 tor0 upper excl", 34'h400, 2'd0, 1'b0, 0, 0, 0);
    put(0, 8'h00, 32'h100);
    put(1, 8'h0F, 32'h200);
    check("R2 tor1 lower incl", 34'h400, 2'd1, 1'b0, 1, 1, 1);
    check("R2 tor1 below", 34'h3FC, 2'd1, 1'b0, 0, 0, 0);
    check("R2 tor1 top word", 34'h7FF, 2'd1, 1'b0, 1, 1, 1);
    check("R2 tor1 upper excl", 34'h800, 2'd1, 1'b0, 0, 0, 0);
    put(0, 8'h00, 32'h200);
    put(1, 8'h0F, 32'h100);
    check("R2 inverted bounds", 34'h500, 2'd0, 1'b0, 0, 0, 0);

    // R3: single word
    clear_all();
    put(3, 8'h17, 32'h50);
    check("R3 na4 first byte", 34'h140, 2'd0, 1'b0, 1, 1, 3);
    check("R3 na4 last byte", 34'h143, 2'd0, 1'b0, 1, 1, 3);
    check("R3 na4 next word", 34'h144, 2'd0, 1'b0, 0, 0, 0);
    check("R3 na4 prev word", 34'h13F, 2'd0, 1'b0, 0, 0, 0);

    // R4: power-of-two region, 32 bytes at 0x800
    clear_all();
    put(4, 8'h1F, 32'h203);
    check("R4 napot base", 34'h800, 2'd0, 1'b0, 1, 1, 4);
    check("R4 napot top", 34'h81F, 2'd0, 1'b0, 1, 1, 4);
    check("R4 napot above", 34'h820, 2'd0, 1'b0, 0, 0, 0);
    check("R4 napot below", 34'h7FF, 2'd0, 1'b0, 0, 0, 0);
    put(4, 8'h1F, 32'h200);
    check("R4 napot 8B top", 34'h807, 2'd0, 1'b0, 1, 1, 4);
    check("R4 napot 8B above", 34'h808, 2'd0, 1'b0, 0, 0, 0);
    put(4, 8'h1F, 32'hFFFF_FFFF);
    check("R4 napot all", 34'h3_FFFF_FFFC, 2'd0, 1'b0, 1, 1, 4);

    // R5: priority among overlapping entries
    clear_all();
    put(2, 8'h10, 32'h10);
    put(5, 8'h1F, 32'h0FF);
    check("R5 low index wins", 34'h40, 2'd0, 1'b0, 0, 1, 2);
    check("R5 only high index", 34'h80, 2'd0, 1'b0, 1, 1, 5);
    put(6, 8'h1F, 32'h10);
    check("R5 higher duplicate", 34'h40, 2'd2, 1'b0, 0, 1, 2);

    // R6: permission per kind
    clear_all();
    put(0, 8'h11, 32'h10);
    check("R6 read ok", 34'h40, 2'd0, 1'b0, 1, 1, 0);
    check("R6 write denied", 34'h40, 2'd1, 1'b0, 0, 1, 0);
    check("R6 fetch denied", 34'h40, 2'd2, 1'b0, 0, 1, 0);
    put(0, 8'h14, 32'h10);
    check("R6 fetch ok", 34'h40, 2'd2, 1'b0, 1, 1, 0);
    check("R6 fetch alias", 34'h40, 2'd3, 1'b0, 1, 1, 0);
    check("R6 read denied", 34'h40, 2'd0, 1'b0, 0, 1, 0);
    put(0, 8'h13, 32'h10);
    check("R6 write ok", 34'h40, 2'd1, 1'b0, 1, 1, 0);

    // R7 / R8: machine mode and locking
    put(0, 8'h11, 32'h10);
    check("R7 mach unlocked write", 34'h40, 2'd1, 1'b1, 1, 1, 0);
    put(0, 8'h10, 32'h10);
    check("R7 mach unlocked fetch", 34'h40, 2'd2, 1'b1, 1, 1, 0);
    put(0, 8'h91, 32'h10);
    check("R8 locked mach write", 34'h40, 2'd1, 1'b1, 0, 1, 0);
    check("R8 locked mach read", 34'h40, 2'd0, 1'b1, 1, 1, 0);
    check("R8 locked user read", 34'h40, 2'd0, 1'b0, 1, 1, 0);

    // R10: reserved bits ignored
    put(0, 8'hF1, 32'h10);
    check("R10 rsvd locked write", 34'h40, 2'd1, 1'b1, 0, 1, 0);
    put(0, 8'h60, 32'h10);
    check("R10 rsvd off", 34'h40, 2'd0, 1'b0, 0, 0, 0);

    // R9 with entries present but missed
    put(0, 8'h17, 32'h10);
    check("R9 miss mach", 34'h1000, 2'd2, 1'b1, 1, 0, 0);
    check("R9 miss user", 34'h1000, 2'd2, 1'b0, 0, 0, 0);

    // Random configurations, all requirements against the model
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < N; i++)
        put(i, 8'($urandom), AW'($urandom & 32'h3FF));
      for (int j = 0; j < 8; j++)
        check_model("R2 R4 R5 R6 R8 random", PW'($urandom & 32'hFFF),
                    2'($urandom), 1'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule